// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that lets an external host read and write a byte-wide register space of up to 8192 locations. The host lowers chip select, clocks in a 16-bit instruction header, and then moves one or more data bytes. The header holds a read/write flag, a two-bit byte-count code and a 13-bit start address. On the inside, every completed write byte becomes a one-cycle write strobe with address and data. Every read byte is fetched with a one-cycle read strobe before its first bit leaves the block.

The serial pins are oversampled on the block's own clock, so SCLK, chip select and the data input may be fully asynchronous to it. Address 0 is not forwarded to the register bus. It holds the port's own configuration byte, which selects LSB-first shifting and a four-wire mode with a separate data-out pin. The byte is symmetric: bit 7 mirrors bit 0 and bit 6 mirrors bit 1. The port therefore decodes it correctly whatever the current shift order is. In the default three-wire mode, the single data pin is turned around and driven by the port only while a read is in its data phase.

Top module: `spi_regport`

## Requirements
- R1: After reset, reg_wr, reg_rd, sdio_oe, sdio_o and sdo are all 0, and the configuration byte at address 0 reads back as 0x00 (MSB-first, three-wire).
- R2: A transfer begins with chip select low. The first 16 bits sampled on rising SCLK edges form the header. In MSB-first order the header is the read flag (1 = read), the count code bit 1, the count code bit 0, and then address bits 12 down to 0.
- R3: Count code 0, 1 and 2 transfer 1, 2 and 3 data bytes. After the last byte, further SCLK edges have no effect until chip select rises. Code 3 streams bytes until chip select rises.
- R4: After each byte the address steps down by one in MSB-first mode and up by one in LSB-first mode, wrapping modulo 8192.
- R5: Each completed write byte gives exactly one single-cycle reg_wr pulse carrying that byte's address and data. reg_wr and reg_rd are never high together.
- R6: For each read byte, a single-cycle reg_rd pulse is issued at that byte's address before its first bit is launched. The bits are launched after falling SCLK edges, bit 7 first in MSB-first mode and bit 0 first in LSB-first mode.
- R7: In three-wire mode, sdio_oe is 1 only while chip select is low during the data phase of a read. It is 0 throughout every header and every write.
- R8: Configuration bit 1 (mirror bit 6) selects four-wire mode. In four-wire mode read data leaves on sdo and sdio_oe stays 0. In three-wire mode sdo stays 0.
- R9: Configuration bit 0 (mirror bit 7) selects LSB-first mode. In LSB-first mode both the header and the data are shifted in reverse order, so the header starts with address bit 0 and ends with the read flag.
- R10: Accesses to address 0 never reach the register bus. A write to address 0 sets a mode bit if either of its two mirrored copies is 1, and takes effect for later bits. A read of address 0 returns the mirrored form, with bits 7 and 0 both equal to LSB-first, bits 6 and 1 both equal to four-wire, and all other bits 0.
- R11: In a 1- to 3-byte transfer, chip select raised at a byte boundary of the data phase pauses the transfer. The transfer continues with the next byte once chip select is low again.
- R12: Chip select raised during the header, in the middle of a data byte, or at any point of a streaming transfer aborts it. A partial byte is discarded, and the next low chip select starts a new header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Serial data in (input side of the bidirectional pin) |
| sdio_o | output | 1 | Read data for the bidirectional pin |
| sdio_oe | output | 1 | Output enable for the bidirectional pin |
| sdo | output | 1 | Read data on the separate pin in four-wire mode |
| reg_addr | output | ADDR_W | Register-bus address |
| reg_wr | output | 1 | Register-bus write strobe, one cycle |
| reg_wdata | output | 8 | Register-bus write data |
| reg_rd | output | 1 | Register-bus read strobe, one cycle |
| reg_rdata | input | 8 | Register-bus read data, valid in the reg_rd cycle |

## Verification
A serial pin change reaches the edge detector after SYNC_STAGES clocks and changes the state at the next clock. A strobe or launched read bit is therefore visible three clocks after the SCLK edge at default parameters. The bench holds each SCLK half period for eight clocks and samples read data and sdio_oe at the last falling clock edge before it raises SCLK, which is well after the launch. Register strobes are logged at every rising clock edge by a monitor. They are compared only after chip select has been high for twelve clocks, so each strobe, issued at most four clocks after its byte's last SCLK edge, is already in the log.

// File: rtl/spi_regport_pkg.sv
`timescale 1ns/1ps
package spi_regport_pkg;
   localparam int HDR_BITS  = 16;
   localparam int BYTE_BITS = 8;
   localparam logic [1:0] CNT_STREAM = 2'b11;

   typedef enum logic [1:0] {
      PH_HDR  = 2'd0,
      PH_DATA = 2'd1,
      PH_DONE = 2'd2
   } phase_t;
endpackage

// File: rtl/spi_regport_sync.sv
`timescale 1ns/1ps
// Oversampling synchronizer for the three serial inputs, with SCLK edge detect.
module spi_regport_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic sclk_i,
   input  logic sdi_i,
   output logic cs_n_o,
   output logic sclk_rise_o,
   output logic sclk_fall_o,
   output logic sdi_o
);
   // each stage holds {sdi, sclk, cs_n}
   logic [STAGES-1:0][2:0] pipe;
   logic                   sclk_prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_regport_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) pipe[k] <= 3'b001;
         sclk_prev <= 1'b0;
      end else begin
         pipe      <= {pipe[STAGES-2:0], {sdi_i, sclk_i, cs_n_i}};
         sclk_prev <= pipe[STAGES-1][1];
      end
   end

   assign cs_n_o      = pipe[STAGES-1][0];
   assign sdi_o       = pipe[STAGES-1][2];
   assign sclk_rise_o =  pipe[STAGES-1][1] & ~sclk_prev;
   assign sclk_fall_o = ~pipe[STAGES-1][1] &  sclk_prev;
endmodule

// File: rtl/spi_regport_cfg.sv
`timescale 1ns/1ps
// Port configuration byte: decoded from either mirrored half.
module spi_regport_cfg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [3:0] wbits,     // {bit7, bit6, bit1, bit0} of the written byte
   output logic       lsb_first,
   output logic       four_wire,
   output logic [7:0] rd_byte
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lsb_first <= 1'b0;
         four_wire <= 1'b0;
      end else if (we) begin
         lsb_first <= wbits[3] | wbits[0];
         four_wire <= wbits[2] | wbits[1];
      end
   end

   assign rd_byte = {lsb_first, four_wire, 4'b0000, four_wire, lsb_first};
endmodule

// File: rtl/spi_regport_tx.sv
`timescale 1ns/1ps
// Read-data serializer: loaded per byte, one bit launched per falling SCLK.
module spi_regport_tx #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         shift,
   input  logic         lsb_first,
   output logic         bit_o
);
   logic [W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         bit_o <= 1'b0;
      end else if (load) begin
         sh <= din;
      end else if (shift) begin
         if (lsb_first) begin
            bit_o <= sh[0];
            sh    <= {1'b0, sh[W-1:1]};
         end else begin
            bit_o <= sh[W-1];
            sh    <= {sh[W-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/spi_regport.sv
`timescale 1ns/1ps
module spi_regport
   import spi_regport_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdio_i,
   output logic              sdio_o,
   output logic              sdio_oe,
   output logic              sdo,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr,
   output logic [7:0]        reg_wdata,
   output logic              reg_rd,
   input  logic [7:0]        reg_rdata
);
   localparam int CNT_W = $clog2(HDR_BITS);

   generate
      if (ADDR_W < 1 || ADDR_W > 13) begin : g_bad_addr_w
         $error("spi_regport: ADDR_W must lie in 1..13");
      end
   endgenerate

   // synchronized pins
   logic csn_s, sclk_rise, sclk_fall, sdi_s;

   spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_i      (cs_n),
      .sclk_i      (sclk),
      .sdi_i       (sdio_i),
      .cs_n_o      (csn_s),
      .sclk_rise_o (sclk_rise),
      .sclk_fall_o (sclk_fall),
      .sdi_o       (sdi_s)
   );

   // configuration byte
   logic       cfg_we;
   logic [3:0] cfg_wbits;
   logic       lsb_first, four_wire;
   logic [7:0] cfg_byte;

   spi_regport_cfg u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .wbits     (cfg_wbits),
      .lsb_first (lsb_first),
      .four_wire (four_wire),
      .rd_byte   (cfg_byte)
   );

   // transfer state
   phase_t             phase;
   logic [CNT_W-1:0]   cnt;
   logic [HDR_BITS-1:0] sr;
   logic               is_rd, stream;
   logic [1:0]         left;
   logic [ADDR_W-1:0]  cur_addr, acc_addr;
   logic               wr_p, rd_pend, rd_int;
   logic [7:0]         wdata_q;

   logic [HDR_BITS-1:0] sr_nxt;
   logic [7:0]          byte_nxt;
   logic [ADDR_W-1:0]   hdr_addr, step_addr;
   logic                stall_ok, launch, out_bit;

   always_comb begin
      sr_nxt    = lsb_first ? {sdi_s, sr[HDR_BITS-1:1]} : {sr[HDR_BITS-2:0], sdi_s};
      byte_nxt  = lsb_first ? sr_nxt[HDR_BITS-1:HDR_BITS-BYTE_BITS] : sr_nxt[BYTE_BITS-1:0];
      hdr_addr  = sr_nxt[ADDR_W-1:0];
      step_addr = lsb_first ? cur_addr + ADDR_W'(1) : cur_addr - ADDR_W'(1);
      stall_ok  = (phase == PH_DATA) && (cnt == '0) && !stream;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_HDR;
         cnt       <= '0;
         sr        <= '0;
         is_rd     <= 1'b0;
         stream    <= 1'b0;
         left      <= 2'd0;
         cur_addr  <= '0;
         acc_addr  <= '0;
         wr_p      <= 1'b0;
         rd_pend   <= 1'b0;
         rd_int    <= 1'b0;
         wdata_q   <= '0;
         cfg_we    <= 1'b0;
         cfg_wbits <= '0;
      end else begin
         wr_p    <= 1'b0;
         rd_pend <= 1'b0;
         cfg_we  <= 1'b0;
         if (csn_s) begin
            // a counted transfer paused at a byte boundary keeps its state
            if (!stall_ok) begin
               phase <= PH_HDR;
               cnt   <= '0;
            end
         end else if (sclk_rise) begin
            unique case (phase)
               PH_HDR: begin
                  sr <= sr_nxt;
                  if (cnt == CNT_W'(HDR_BITS-1)) begin
                     phase    <= PH_DATA;
                     cnt      <= '0;
                     is_rd    <= sr_nxt[15];
                     stream   <= (sr_nxt[14:13] == CNT_STREAM);
                     left     <= sr_nxt[14:13];
                     cur_addr <= hdr_addr;
                     if (sr_nxt[15]) begin
                        rd_pend  <= 1'b1;
                        rd_int   <= (hdr_addr == '0);
                        acc_addr <= hdr_addr;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PH_DATA: begin
                  sr <= sr_nxt;
                  if (cnt == CNT_W'(BYTE_BITS-1)) begin
                     cnt      <= '0;
                     cur_addr <= step_addr;
                     if (!is_rd) begin
                        acc_addr <= cur_addr;
                        if (cur_addr == '0) begin
                           cfg_we    <= 1'b1;
                           cfg_wbits <= {byte_nxt[7], byte_nxt[6], byte_nxt[1], byte_nxt[0]};
                        end else begin
                           wr_p    <= 1'b1;
                           wdata_q <= byte_nxt;
                        end
                     end
                     if (!stream && left == 2'd0) begin
                        phase <= PH_DONE;
                     end else begin
                        if (!stream) left <= left - 2'd1;
                        if (is_rd) begin
                           rd_pend  <= 1'b1;
                           rd_int   <= (step_addr == '0);
                           acc_addr <= step_addr;
                        end
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign launch = sclk_fall & ~csn_s & (phase == PH_DATA) & is_rd;

   spi_regport_tx #(.W(BYTE_BITS)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rd_pend),
      .din       (rd_int ? cfg_byte : reg_rdata),
      .shift     (launch),
      .lsb_first (lsb_first),
      .bit_o     (out_bit)
   );

   assign reg_addr  = acc_addr;
   assign reg_wr    = wr_p;
   assign reg_wdata = wdata_q;
   assign reg_rd    = rd_pend & ~rd_int;
   assign sdio_oe   = ~csn_s & (phase == PH_DATA) & is_rd & ~four_wire;
   assign sdio_o    = out_bit & ~four_wire;
   assign sdo       = out_bit &  four_wire;
endmodule

// File: rtl/spi_regport_chk.sv
`timescale 1ns/1ps
module spi_regport_chk #(
   parameter int ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csn_s,
   input logic              four_wire,
   input logic              sdio_oe,
   input logic              sdo,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr
);
   assert_rw_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));

   assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);

   assert_oe_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sdio_oe |-> !csn_s);

   assert_oe_off_4w_R8: assert property (@(posedge clk) disable iff (!rst_n)
      four_wire |-> !sdio_oe);

   assert_sdo_quiet_3w_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !four_wire |-> !sdo);

   assert_cfg_hidden_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> reg_addr != '0);

   assert_cfg_hidden_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> reg_addr != '0);
endmodule

bind spi_regport spi_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .csn_s     (csn_s),
   .four_wire (four_wire),
   .sdio_oe   (sdio_oe),
   .sdo       (sdo),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr)
);

// File: tb/spi_regport_test.sv
`timescale 1ns/1ps
module spi_regport_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdio_i = 1'b0;
   logic        sdio_o, sdio_oe, sdo, reg_wr, reg_rd;
   logic [12:0] reg_addr;
   logic [7:0]  reg_wdata, reg_rdata;

   always #2 clk = ~clk;   // 250 MHz

   spi_regport uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
      .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
   );

   // register-side model: read data is a function of the address
   assign reg_rdata = reg_addr[7:0] ^ 8'h5A;

   int          n_chk = 0, n_fail = 0;
   int          wr_n = 0, rd_n = 0, oe_bad = 0;
   logic [12:0] wl_a [64];
   logic [7:0]  wl_d [64];
   bit          m_lsb = 1'b0, m_fw = 1'b0;

   always @(posedge clk) begin
      if (reg_wr) begin
         wl_a[wr_n % 64] <= reg_addr;
         wl_d[wr_n % 64] <= reg_wdata;
         wr_n <= wr_n + 1;
      end
      if (reg_rd) rd_n <= rd_n + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_cfg();
      return {m_lsb, m_fw, 4'b0000, m_fw, m_lsb};
   endfunction

   function automatic logic [7:0] exp_rd(input logic [12:0] a);
      return (a == 13'd0) ? exp_cfg() : (a[7:0] ^ 8'h5A);
   endfunction

   function automatic logic [12:0] step(input logic [12:0] a);
      return m_lsb ? a + 13'd1 : a - 13'd1;
   endfunction

   task automatic spi_txn(input bit rd, input bit [1:0] wc, input bit [12:0] a,
                          input bit [39:0] wd, input int nb, input bit stall,
                          input int cut, output bit [39:0] rb);
      bit [15:0] hdr;
      int        k, j, pos;
      bit        b;
      hdr = {rd, wc, a};
      rb = '0;
      oe_bad = 0;
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 16 + 8 * nb; i++) begin
         if (cut >= 0 && i == cut) break;
         sclk = 1'b0;
         if (stall && i > 16 && ((i - 16) % 8) == 0) begin
            repeat (4) @(negedge clk);
            cs_n = 1'b1;
            repeat (10) @(negedge clk);
            cs_n = 1'b0;
            repeat (4) @(negedge clk);
         end
         pos = 0;
         if (i < 16) begin
            b = m_lsb ? hdr[i] : hdr[15 - i];
         end else begin
            k = (i - 16) / 8;
            j = (i - 16) % 8;
            pos = m_lsb ? (32 - 8 * k + j) : (39 - 8 * k - j);
            b = wd[pos];
         end
         sdio_i = b;
         repeat (8) @(negedge clk);
         if (sdio_oe !== (i >= 16 && rd && !m_fw)) oe_bad++;
         if (i >= 16) rb[pos] = m_fw ? sdo : sdio_o;
         sclk = 1'b1;
         repeat (8) @(negedge clk);
      end
      sclk = 1'b0;
      repeat (8) @(negedge clk);
      cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic set_mode(input bit lsb, input bit fw);
      bit [39:0] rb;
      spi_txn(1'b0, 2'd0, 13'd0, {lsb, fw, 4'b0000, fw, lsb, 32'h0}, 1, 1'b0, -1, rb);
      m_lsb = lsb;
      m_fw  = fw;
   endtask

   typedef struct packed {
      bit        rd;
      bit [1:0]  wc;
      bit [12:0] addr;
      bit [23:0] dat;
      bit        lsb;
      bit        fw;
      bit [2:0]  exp_n;
   } vec_t;

   localparam vec_t VEC [7] = '{
      '{1'b0, 2'd0, 13'h0010, 24'h3C0000, 1'b0, 1'b0, 3'd1},  // R2 R5 single write
      '{1'b0, 2'd2, 13'h0105, 24'hA1B2C3, 1'b0, 1'b0, 3'd3},  // R3 R4 three bytes, down
      '{1'b1, 2'd1, 13'h0020, 24'h000000, 1'b0, 1'b0, 3'd2},  // R6 R7 read, turnaround
      '{1'b0, 2'd1, 13'h0030, 24'h112200, 1'b1, 1'b0, 3'd2},  // R9 R4 LSB-first, up
      '{1'b1, 2'd2, 13'h1FFF, 24'h000000, 1'b1, 1'b0, 3'd3},  // R4 wrap, R10 via addr 0
      '{1'b1, 2'd0, 13'h0044, 24'h000000, 1'b0, 1'b1, 3'd1},  // R8 four-wire read
      '{1'b0, 2'd0, 13'h00AB, 24'h5E0000, 1'b1, 1'b1, 3'd1}   // R8 R9 write in both modes
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit [39:0]   rb;
      logic [12:0] a;
      int          w0, r0;
      repeat (5) @(negedge clk);
      // R1: idle outputs during and after reset
      chk("R1 idle outputs", {27'd0, reg_wr, reg_rd, sdio_oe, sdio_o, sdo}, 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 idle outputs after reset", {27'd0, reg_wr, reg_rd, sdio_oe, sdio_o, sdo}, 32'd0);
      spi_txn(1'b1, 2'd0, 13'd0, '0, 1, 1'b0, -1, rb);
      chk("R1 R10 config reset value", rb[39:32], 8'h00);

      // table walk
      for (int v = 0; v < 7; v++) begin
         if (VEC[v].lsb != m_lsb || VEC[v].fw != m_fw) set_mode(VEC[v].lsb, VEC[v].fw);
         w0 = wr_n;
         r0 = rd_n;
         spi_txn(VEC[v].rd, VEC[v].wc, VEC[v].addr, {VEC[v].dat, 16'h0},
                 int'(VEC[v].wc) + 1, 1'b0, -1, rb);
         a = VEC[v].addr;
         for (int k = 0; k < int'(VEC[v].exp_n); k++) begin
            if (VEC[v].rd) begin
               chk($sformatf("R6 R4 vec%0d read byte%0d", v, k), rb[39 - 8 * k -: 8], exp_rd(a));
            end else begin
               chk($sformatf("R5 R4 vec%0d write addr%0d", v, k), wl_a[(w0 + k) % 64], a);
               chk($sformatf("R5 R9 vec%0d write data%0d", v, k), wl_d[(w0 + k) % 64],
                   VEC[v].dat[23 - 8 * k -: 8]);
            end
            a = step(a);
         end
         chk($sformatf("R3 R5 vec%0d write count", v), wr_n - w0,
             VEC[v].rd ? 0 : int'(VEC[v].exp_n));
         chk($sformatf("R7 R8 vec%0d data pin enable", v), oe_bad, 0);
      end
      set_mode(1'b0, 1'b0);

      // R3: streaming write of five bytes
      w0 = wr_n;
      spi_txn(1'b0, 2'd3, 13'h0050, 40'h0102030405, 5, 1'b0, -1, rb);
      chk("R3 stream write count", wr_n - w0, 5);
      chk("R3 R4 stream last addr", wl_a[(w0 + 4) % 64], 13'h004C);
      chk("R3 stream last data", wl_d[(w0 + 4) % 64], 8'h05);

      // R3: extra clocks after a counted transfer are ignored
      w0 = wr_n;
      spi_txn(1'b0, 2'd0, 13'h0070, 40'h9988000000, 2, 1'b0, -1, rb);
      chk("R3 counted ignores extra byte", wr_n - w0, 1);
      chk("R3 counted data", wl_d[w0 % 64], 8'h99);

      // R12: abort inside the header
      w0 = wr_n;
      spi_txn(1'b0, 2'd0, 13'h0066, 40'hEE00000000, 1, 1'b0, 7, rb);
      spi_txn(1'b0, 2'd0, 13'h0061, 40'h7700000000, 1, 1'b0, -1, rb);
      chk("R12 header abort count", wr_n - w0, 1);
      chk("R12 header abort addr", wl_a[w0 % 64], 13'h0061);
      chk("R12 header abort data", wl_d[w0 % 64], 8'h77);

      // R12: abort inside a data byte
      w0 = wr_n;
      spi_txn(1'b0, 2'd1, 13'h0080, 40'h1234000000, 2, 1'b0, 28, rb);
      chk("R12 mid-byte abort count", wr_n - w0, 1);
      spi_txn(1'b0, 2'd0, 13'h0081, 40'h5600000000, 1, 1'b0, -1, rb);
      chk("R12 after abort data", wl_d[(w0 + 1) % 64], 8'h56);

      // R11: paused three-byte write and paused two-byte read
      w0 = wr_n;
      spi_txn(1'b0, 2'd2, 13'h0090, 40'hDEADBE0000, 3, 1'b1, -1, rb);
      chk("R11 stalled write count", wr_n - w0, 3);
      chk("R11 stalled write addr2", wl_a[(w0 + 2) % 64], 13'h008E);
      chk("R11 stalled write data2", wl_d[(w0 + 2) % 64], 8'hBE);
      r0 = rd_n;
      spi_txn(1'b1, 2'd1, 13'h00A0, '0, 2, 1'b1, -1, rb);
      chk("R11 stalled read byte0", rb[39:32], 8'hA0 ^ 8'h5A);
      chk("R11 stalled read byte1", rb[31:24], 8'h9F ^ 8'h5A);
      chk("R6 stalled read strobes", rd_n - r0, 2);

      // R12: chip select high at a byte boundary of a stream aborts it
      w0 = wr_n;
      spi_txn(1'b0, 2'd3, 13'h00C0, 40'h0102000000, 2, 1'b1, -1, rb);
      chk("R12 stream abort count", wr_n - w0, 1);

      // R10: decode from either half, hidden from the bus, mirrored readback
      w0 = wr_n;
      spi_txn(1'b0, 2'd0, 13'd0, 40'h8000000000, 1, 1'b0, -1, rb);
      chk("R10 config write hidden", wr_n - w0, 0);
      m_lsb = 1'b1;
      spi_txn(1'b1, 2'd0, 13'd0, '0, 1, 1'b0, -1, rb);
      chk("R10 R9 upper-half decode", rb[39:32], 8'h81);
      spi_txn(1'b0, 2'd0, 13'd0, 40'h4000000000, 1, 1'b0, -1, rb);
      m_lsb = 1'b0;
      m_fw  = 1'b1;
      r0 = rd_n;
      spi_txn(1'b1, 2'd0, 13'd0, '0, 1, 1'b0, -1, rb);
      chk("R10 R8 four-wire readback", rb[39:32], 8'h42);
      chk("R10 config read hidden", rd_n - r0, 0);
      chk("R8 no turnaround in four-wire", oe_bad, 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule